// File: doc/BRIEF.md
# Byte-Counted SPI Master

This engine drives a mode-0 SPI bus from a bank of sixteen byte-wide slots. Software first loads the slots through a plain register port. It then issues one 16-bit command that holds two byte counts. The upper byte is the number of command bytes sent toward the device. The lower byte is the total number of bytes clocked. The engine produces eight SCLK periods per clocked byte, sends each slot MSB first, and writes the byte sampled from MISO back into the same slot. After the transfer, each slot holds the device's reply for that byte position.

Clocking past the command bytes needs no special handling. A trailing slot still drives its stored contents on MOSI. Received data always comes from MISO, so a register read placed after the command bytes returns the device's answer. The command port follows a valid/ready rule. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. A command presented while `cmd_ready` is low is dropped, not held, so the issuer must wait for `cmd_ready` before it presents a command. The `tx_slot` pin marks the slots that fall inside the clamped transmit count, for logic that needs to know the direction phase.

Top module: `spi_split_master`

## Requirements
- R1: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_word[7:0]` is the total byte count and `cmd_word[15:8]` is the transmit byte count.
- R2: An accepted command with a total count N from 1 to 16 gives exactly 8×N rising SCLK edges (mode 0). SCLK stays low whenever `cs_n` is high.
- R3: Byte k of a transfer is driven on MOSI from slot k, MSB first. This holds for every slot, including slots at or past the transmit count. MOSI changes only while SCLK is low.
- R4: The byte sampled from MISO on the rising edges of byte k is stored in slot k, never the MOSI byte. Slots at index N and above keep their contents.
- R5: `cs_n` falls on the accepting clock edge. The first rising SCLK edge follows one half period later. `cs_n` rises one half period after the last falling edge, and `done` is set on that same edge.
- R6: `busy` is high and `cmd_ready` is low from acceptance until `cs_n` rises. A command offered during that time is dropped.
- R7: A total count of 0 or above 16 sets `done` on the accepting edge. It produces no SCLK edge, `cs_n` stays high and `busy` stays low.
- R8: Each SCLK half period lasts `clk_half` system clocks. A value of 0 acts as 1, so the minimum ratio is 2.
- R9: A transmit count above the total count is clamped to the total. `tx_slot` is high for the 8×min(TX,N) bit periods of slots below the clamped count.
- R10: After reset, `cs_n`=1, `sclk`=0, `busy`=0, `done`=0 and all slots read 0. `done` stays set until the next command is accepted.
- R11: Slot writes through the register port are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_half | input | 8 | System clocks per SCLK half period (0 acts as 1) |
| reg_we | input | 1 | Slot write strobe |
| reg_waddr | input | 4 | Slot written |
| reg_wdata | input | 8 | Slot write data |
| reg_raddr | input | 4 | Slot read |
| reg_rdata | output | 8 | Slot read data |
| cmd_valid | input | 1 | Command offered |
| cmd_word | input | 16 | {transmit count, total count} |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished (sticky) |
| tx_slot | output | 1 | Current slot is inside the transmit count |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench places a device model on the bus that returns a byte stream different from the slot contents. Any loopback of MOSI into the slots therefore shows up as a wrong read-back. The vectors cover several shapes of command:
- equal counts, which is full duplex;
- a transmit count below the total, which is write-then-read;
- a single byte;
- a transmit count above the total, which must be clamped;
- a transmit count of zero;
- the full sixteen slots.

These run at divider settings 0, 1, 2 and 3. The edge count separates the total count from the transmit count. The `tx_slot` count exposes the clamp. The chip-select timing shows the half-period lead and trail at each divider setting. Directed cases cover empty commands, a command and a slot write offered while busy, and the stickiness of `done`.

// File: rtl/spi_split_pkg.sv
`timescale 1ns/1ps
package spi_split_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_TRAIL = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spi_split_clkdiv.sv
`timescale 1ns/1ps
module spi_split_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // a zero setting behaves as one clock per half period
  assign lim  = (half == '0) ? '0 : half - 1'b1;
  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= lim;
    else if (cnt == '0)   cnt <= lim;
    else                  cnt <= cnt - 1'b1;
  end

  // R8: with a ratio of 1, a tick in one cycle implies a tick in the next while running
  assert_min_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(tick) && half <= 8'd1 && $past(half) == half) |-> tick);
endmodule

// File: rtl/spi_split_bank.sv
`timescale 1ns/1ps
module spi_split_bank #(
  parameter int SLOTS = 16,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_waddr,
  input  logic [7:0]    sw_wdata,
  input  logic [AW-1:0] sw_raddr,
  output logic [7:0]    sw_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata
);
  logic [7:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   q <= '0;
      else if (eng_we && eng_addr == AW'(g))        q <= eng_wdata;
      else if (sw_we && sw_waddr == AW'(g))         q <= sw_wdata;
    end
    assign slot_q[g] = q;
  end

  assign sw_rdata  = slot_q[sw_raddr];
  assign eng_rdata = slot_q[eng_addr];

  // R11: software writes are gated off while the engine owns the bank
  assert_single_writer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_we && eng_we));
endmodule

// File: rtl/spi_split_ctrl.sv
`timescale 1ns/1ps
module spi_split_ctrl
  import spi_split_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int AW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_valid,
  input  logic [15:0]   cmd_word,
  output logic          cmd_ready,
  output logic          busy,
  output logic          done,
  output logic          run,
  output logic [AW-1:0] slot,
  input  logic [7:0]    slot_byte,
  output logic          wb_we,
  output logic [7:0]    wb_data,
  output logic          tx_slot,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          cs_n
);
  eng_state_t    state;
  logic [AW-1:0] slot_q;
  logic [2:0]    bit_q;
  logic [CW-1:0] tot_q, tx_q;
  logic          sclk_q, cs_q, done_q;
  logic [7:0]    rx_sh;

  logic [7:0] tot_dec, tx_dec;
  logic       empty_cmd, accept, last_slot, fall_tick, rise_tick;

  assign tot_dec   = cmd_word[7:0];
  assign tx_dec    = (cmd_word[15:8] > cmd_word[7:0]) ? cmd_word[7:0] : cmd_word[15:8];
  assign empty_cmd = (tot_dec == 8'd0) || (tot_dec > 8'(SLOTS));
  assign accept    = cmd_valid && (state == ENG_IDLE);
  assign last_slot = (CW'(slot_q) + 1'b1) == tot_q;
  assign rise_tick = (state == ENG_SHIFT) && tick && !sclk_q;
  assign fall_tick = (state == ENG_SHIFT) && tick && sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      slot_q <= '0;
      bit_q  <= 3'd7;
      tot_q  <= '0;
      tx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      rx_sh  <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (cmd_valid) begin
          if (empty_cmd) begin
            done_q <= 1'b1;
          end else begin
            state  <= ENG_SHIFT;
            cs_q   <= 1'b0;
            done_q <= 1'b0;
            slot_q <= '0;
            bit_q  <= 3'd7;
            tot_q  <= CW'(tot_dec);
            tx_q   <= CW'(tx_dec);
          end
        end
        ENG_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[6:0], miso};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd0) begin
              bit_q <= 3'd7;
              if (last_slot) state <= ENG_TRAIL;
              else           slot_q <= slot_q + 1'b1;
            end else begin
              bit_q <= bit_q - 1'b1;
            end
          end
        end
        ENG_TRAIL: if (tick) begin
          cs_q   <= 1'b1;
          done_q <= 1'b1;
          state  <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ENG_IDLE);
  assign busy      = (state != ENG_IDLE);
  assign run       = busy;
  assign done      = done_q;
  assign slot      = slot_q;
  assign sclk      = sclk_q;
  assign cs_n      = cs_q;
  assign mosi      = busy ? slot_byte[bit_q] : 1'b0;
  assign wb_we     = fall_tick && (bit_q == 3'd0);
  assign wb_data   = rx_sh;
  assign tx_slot   = (state == ENG_SHIFT) && (CW'(slot_q) < tx_q);

  // checker bookkeeping: rising edges since the last accepted command
  logic [CW+2:0] chk_rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chk_rises <= '0;
    else if (accept)    chk_rises <= '0;
    else if (rise_tick) chk_rises <= chk_rises + 1'b1;
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_edge_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_TRAIL && tick) |-> (chk_rises == {tot_q, 3'b000}));
  assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_done_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !(state == ENG_TRAIL && tick)) |=> (busy && $stable(tot_q) && $stable(tx_q)));
  assert_sclk_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(tick));
endmodule

// File: rtl/spi_split_master.sv
`timescale 1ns/1ps
module spi_split_master #(
  parameter int SLOTS = 16,
  parameter int DIV_W = 8,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_half,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_waddr,
  input  logic [7:0]       reg_wdata,
  input  logic [AW-1:0]    reg_raddr,
  output logic [7:0]       reg_rdata,
  input  logic             cmd_valid,
  input  logic [15:0]      cmd_word,
  output logic             cmd_ready,
  output logic             busy,
  output logic             done,
  output logic             tx_slot,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  logic          tick, run, wb_we;
  logic [AW-1:0] eng_slot;
  logic [7:0]    eng_byte, wb_data;

  spi_split_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .half(clk_half), .tick(tick)
  );

  spi_split_bank #(.SLOTS(SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .sw_we(reg_we && !busy), .sw_waddr(reg_waddr), .sw_wdata(reg_wdata),
    .sw_raddr(reg_raddr), .sw_rdata(reg_rdata),
    .eng_we(wb_we), .eng_addr(eng_slot), .eng_wdata(wb_data), .eng_rdata(eng_byte)
  );

  spi_split_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .run(run),
    .slot(eng_slot), .slot_byte(eng_byte), .wb_we(wb_we), .wb_data(wb_data),
    .tx_slot(tx_slot), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );
endmodule

// File: tb/spi_split_master_test.sv
`timescale 1ns/1ps
module spi_split_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_half = 8'd1;
  logic       reg_we = 1'b0;
  logic [3:0] reg_waddr = '0, reg_raddr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic       cmd_ready, busy, done, tx_slot, sclk, mosi, cs_n;
  logic       miso = 1'b0;

  always #5 clk = ~clk;

  spi_split_master uut (
    .clk(clk), .rst_n(rst_n), .clk_half(clk_half),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .tx_slot(tx_slot),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int errors = 0, checks = 0;
  int rises = 0, txs = 0;
  time t_csf, t_csr, t_rise1, t_fall;
  logic [7:0] dev_bytes [16];
  logic [7:0] mosi_cap [16];

  // device model: drives MISO on falling edges, records MOSI on rising edges
  always @(negedge cs_n) begin
    t_csf = $time;
    miso = dev_bytes[0][7];
  end
  always @(posedge cs_n) t_csr = $time;
  always @(posedge sclk) begin
    if (!cs_n) begin
      if (rises == 0) t_rise1 = $time;
      if (rises < 128) mosi_cap[rises >> 3][7 - (rises & 7)] = mosi;
      if (tx_slot) txs++;
      rises++;
    end
  end
  always @(negedge sclk) begin
    t_fall = $time;
    if (rises < 128) miso = dev_bytes[rises >> 3][7 - (rises & 7)];
  end

  function automatic logic [7:0] tx_pat(input logic [7:0] s, input int i);
    return 8'(s ^ (i * 37));
  endfunction
  function automatic logic [7:0] rx_pat(input logic [7:0] s, input int i);
    return 8'(~s + i * 11 + 1);
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_slot(input int a, input logic [7:0] d);
    reg_we = 1'b1; reg_waddr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_slot(input int a, output logic [7:0] d);
    reg_raddr = 4'(a);
    #1 d = reg_rdata;
  endtask

  task automatic issue(input logic [7:0] tx, input logic [7:0] tot);
    rises = 0; txs = 0;
    cmd_valid = 1'b1; cmd_word = {tx, tot};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done, "watchdog done", done, 1);
  endtask

  // vector: {half, tx count, total count, seed}
  localparam logic [31:0] VECS [7] = '{
    {8'd1, 8'd3,  8'd3,  8'hA5},   // full duplex
    {8'd2, 8'd2,  8'd3,  8'h3C},   // write then read
    {8'd1, 8'd1,  8'd1,  8'hC0},   // single byte
    {8'd3, 8'd3,  8'd4,  8'h11},
    {8'd1, 8'd5,  8'd2,  8'h7E},   // tx clamped to total
    {8'd2, 8'd0,  8'd16, 8'h5A},   // no tx slots, full bank
    {8'd0, 8'd16, 8'd16, 8'hE1}    // divider 0 acts as 1
  };

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0, "R10 reset bus idle", {cs_n, sclk}, 2);
    chk(busy == 1'b0 && done == 1'b0 && cmd_ready == 1'b1, "R10 reset status", {busy, done, cmd_ready}, 1);
    read_slot(5, rd);
    chk(rd == 8'h00, "R10 reset slot", rd, 0);

    foreach (VECS[v]) begin
      logic [7:0] hv, tx, tot, sd;
      int hf, txc;
      {hv, tx, tot, sd} = VECS[v];
      hf  = (hv == 0) ? 1 : int'(hv);
      txc = (tx > tot) ? int'(tot) : int'(tx);
      clk_half = hv;
      for (int i = 0; i < 16; i++) begin
        write_slot(i, tx_pat(sd, i));
        dev_bytes[i] = rx_pat(sd, i);
      end
      issue(tx, tot);
      chk(busy && !cmd_ready, "R6 busy after accept", busy, 1);
      wait_done();
      chk(rises == 8 * int'(tot), "R2 edge count", rises, 8 * int'(tot));
      chk(txs == 8 * txc, "R9 tx slot periods (R1 decode)", txs, 8 * txc);
      chk(t_rise1 - t_csf == time'(hf * 10), "R5 R8 lead time", t_rise1 - t_csf, hf * 10);
      chk(t_csr - t_fall == time'(hf * 10), "R5 R8 trail time", t_csr - t_fall, hf * 10);
      chk(cs_n && !busy, "R5 released", cs_n, 1);
      for (int i = 0; i < 16; i++) begin
        read_slot(i, rd);
        if (i < int'(tot)) begin
          chk(mosi_cap[i] == tx_pat(sd, i), "R3 mosi byte", mosi_cap[i], tx_pat(sd, i));
          chk(rd == rx_pat(sd, i), "R4 captured miso", rd, rx_pat(sd, i));
        end else begin
          chk(rd == tx_pat(sd, i), "R4 untouched slot", rd, tx_pat(sd, i));
        end
      end
      @(negedge clk);
    end

    // R10 done stays set
    repeat (5) @(negedge clk);
    chk(done, "R10 done sticky", done, 1);

    // R7 empty commands
    foreach (dev_bytes[i]) dev_bytes[i] = 8'h00;
    clk_half = 8'd1;
    issue(8'd2, 8'd0);
    chk(done && !busy && cs_n && rises == 0, "R7 total zero", rises, 0);
    repeat (4) @(negedge clk);
    chk(rises == 0 && cs_n, "R7 total zero no clocks", rises, 0);
    issue(8'd1, 8'd17);
    repeat (4) @(negedge clk);
    chk(done && !busy && rises == 0 && cs_n, "R7 total 17", rises, 0);

    // R6 / R11 commands and slot writes while busy
    clk_half = 8'd2;
    write_slot(5, 8'h33);
    issue(8'd1, 8'd2);
    chk(!done, "R10 done cleared on accept", done, 0);
    chk(!cmd_ready, "R6 not ready while busy", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_word = {8'd16, 8'd16};
    @(negedge clk);
    cmd_valid = 1'b0;
    write_slot(5, 8'hEE);
    wait_done();
    repeat (3) @(negedge clk);
    chk(rises == 16, "R6 dropped command", rises, 16);
    chk(!busy, "R6 no second transfer", busy, 0);
    read_slot(5, rd);
    chk(rd == 8'h33, "R11 write while busy", rd, 8'h33);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule